// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a host bus and a 12-bit successive-approximation converter core. It turns the host's control lines into start commands for the core, reports a busy flag for the whole conversion, keeps the finished sample in an output register and presents it on a 12-line data bus. The bus lines carry per-line output enables for the pad drivers. A host can read the whole word at once, or read it as an upper byte followed by a left-justified lower nibble. The read format is picked by the word/byte select and the byte address.

A conversion is requested by a falling level on the read/convert line while the device is enabled and selected. The byte address at that moment picks a short (8-bit) or a full (12-bit) conversion cycle. While the converter is busy, every control input is disregarded and the bus is released. A restart or a shortened conversion is therefore impossible. With select and byte address tied low and enable and word select tied high, the read/convert line alone runs the block. All control inputs are asynchronous and pass through two-flop synchronizers. The core is reached through a start/done/data handshake.

Top module: `adc_host_if`

## Requirements
- R1: A start is accepted when the synchronized read/convert line goes from 1 to 0 while enable is 1, select_n is 0 and busy is 0. busy_o rises on the third rising clock edge after the input change (two synchronizer stages and one register).
- R2: core_start_o is a one-cycle pulse that is high in the same cycle busy_o first reads 1.
- R3: A byte address of 1 at the start selects the short cycle. In that case core_short_o is 1 for the whole conversion and result bits [3:0] are stored as 0. A byte address of 0 selects the full cycle, with core_short_o at 0.
- R4: busy_o falls on the clock edge that samples core_done_i high. On that same edge core_data_i is latched into the result register.
- R5: While busy_o is 1, every data_oe_o bit is 0 and data_o is 0.
- R6: While busy_o is 1, no control input has an effect. A falling edge of read/convert during a conversion never starts another one, either then or after busy_o falls.
- R7: The bus is driven only when enable is 1, select_n is 0, read/convert is 1 and busy is 0. Otherwise data_oe_o and data_o are all 0, and lines whose enable is 0 always read 0.
- R8: With word select at 1, all 12 lines are enabled and data_o equals the result.
- R9: With word select at 0 and byte address at 0, lines [7:0] carry result[11:4] and lines [11:8] are off.
- R10: With word select at 0 and byte address at 1, lines [7:4] carry result[3:0] and lines [3:0] are driven 0. Lines [11:8] are off.
- R11: In stand-alone wiring (select_n 0, byte address 0, enable 1, word select 1), a low pulse on read/convert runs a full conversion. Once busy falls with read/convert high, the full word is driven.
- R12: A change of a control input reaches the bus outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Device select, active low |
| en_i | input | 1 | Device enable, active high |
| rd_nconv_i | input | 1 | 1 = read, falling to 0 = convert |
| byte_addr_i | input | 1 | Byte address; selects short cycle at start |
| word_sel_i | input | 1 | 1 = full-word read, 0 = byte reads |
| core_done_i | input | 1 | Core finished; data valid this cycle |
| core_data_i | input | 12 | Core conversion result |
| core_start_o | output | 1 | One-cycle start command to core |
| core_short_o | output | 1 | Short (8-bit) cycle request to core |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Bus data value |
| data_oe_o | output | 12 | Per-line output enable for bus drivers |

## Verification
Several properties are checked on every cycle. The bus is released while busy. Disabled lines read zero. A start pulse lasts one cycle and coincides with busy rising, and is never issued during a conversion. Busy falls only after a done strobe, and the cycle length flag stays stable within a conversion. Some behaviour can only be shown by the bench's scenarios: the exact synchronizer latency, the byte and nibble placement on the bus, and the masking of the low nibble after a short cycle. The same holds for the fact that an edge swallowed during a conversion never starts a later one, and for stand-alone operation.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    FMT_OFF,
    FMT_WORD,
    FMT_HIGH_BYTE,
    FMT_LOW_NIB
  } rd_fmt_e;
endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl #(
  parameter int DATA_W = 12,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              sel_n_s_i,
  input  logic              rdc_s_i,
  input  logic              addr_s_i,
  input  logic              core_done_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              short_o,
  output logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] HI_MASK = {{(DATA_W-NIB_W){1'b1}}, {NIB_W{1'b0}}};

  logic rdc_q;
  logic start_req;

  // inputs only count while idle; edge tracking runs always so a swallowed edge stays consumed
  assign start_req = rdc_q & ~rdc_s_i & en_s_i & ~sel_n_s_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdc_q    <= 1'b0;
      busy_o   <= 1'b0;
      start_o  <= 1'b0;
      short_o  <= 1'b0;
      result_o <= '0;
    end else begin
      rdc_q   <= rdc_s_i;
      start_o <= start_req;
      if (start_req) begin
        busy_o  <= 1'b1;
        short_o <= addr_s_i;
      end else if (busy_o && core_done_i) begin
        busy_o   <= 1'b0;
        result_o <= short_o ? (core_data_i & HI_MASK) : core_data_i;
      end
    end
  end
endmodule

// File: rtl/adc_host_bus.sv
module adc_host_bus
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              rd_en_i,
  input  logic              word_sel_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o
);
  localparam int NIB_W = DATA_W - BYTE_W;
  localparam logic [DATA_W-1:0] BYTE_OE = {{NIB_W{1'b0}}, {BYTE_W{1'b1}}};

  rd_fmt_e fmt;

  always_comb begin
    if (!rd_en_i)       fmt = FMT_OFF;
    else if (word_sel_i) fmt = FMT_WORD;
    else if (!addr_i)   fmt = FMT_HIGH_BYTE;
    else                fmt = FMT_LOW_NIB;
  end

  always_comb begin
    data_o = '0;
    oe_o   = '0;
    unique case (fmt)
      FMT_WORD: begin
        data_o = result_i;
        oe_o   = '1;
      end
      FMT_HIGH_BYTE: begin
        data_o[BYTE_W-1:0] = result_i[DATA_W-1 -: BYTE_W];
        oe_o               = BYTE_OE;
      end
      FMT_LOW_NIB: begin
        data_o[BYTE_W-1 -: NIB_W] = result_i[NIB_W-1:0];
        oe_o                      = BYTE_OE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              en_i,
  input  logic              rd_nconv_i,
  input  logic              byte_addr_i,
  input  logic              word_sel_i,
  input  logic              core_done_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              core_start_o,
  output logic              core_short_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int NIB_W  = DATA_W - BYTE_W;
  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic sel_n_s, en_s, rdc_s, addr_s, word_s;
  logic [DATA_W-1:0] result;
  logic rd_en;

  assign ctrl_raw = {sel_ni, en_i, rd_nconv_i, byte_addr_i, word_sel_i};
  assign {sel_n_s, en_s, rdc_s, addr_s, word_s} = ctrl_s;

  adc_host_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_raw),
    .q_o    (ctrl_s)
  );

  adc_host_ctrl #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_s_i      (en_s),
    .sel_n_s_i   (sel_n_s),
    .rdc_s_i     (rdc_s),
    .addr_s_i    (addr_s),
    .core_done_i (core_done_i),
    .core_data_i (core_data_i),
    .busy_o      (busy_o),
    .start_o     (core_start_o),
    .short_o     (core_short_o),
    .result_o    (result)
  );

  assign rd_en = en_s & ~sel_n_s & rdc_s & ~busy_o;

  adc_host_bus #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bus (
    .rd_en_i    (rd_en),
    .word_sel_i (word_s),
    .addr_i     (addr_s),
    .result_i   (result),
    .data_o     (data_o),
    .oe_o       (data_oe_o)
  );
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              start_i,
  input logic              short_i,
  input logic              done_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] oe_i
);
  assert_start_with_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> start_i);

  assert_start_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i);

  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !$past(busy_i));

  assert_busy_ends_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(done_i));

  assert_bus_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (oe_i == '0 && data_i == '0));

  assert_off_lines_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i & ~oe_i) == '0);

  assert_short_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(short_i));
endmodule

bind adc_host_if adc_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_o),
  .start_i (core_start_o),
  .short_i (core_short_o),
  .done_i  (core_done_i),
  .data_i  (data_o),
  .oe_i    (data_oe_o)
);

// File: tb/tb_adc_host_if.sv
module tb_adc_host_if;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ni = 1'b1, en_i = 1'b1, rd_nconv_i = 1'b1, byte_addr_i = 1'b0, word_sel_i = 1'b1;
  logic core_done_i = 1'b0;
  logic [11:0] core_data_i = '0;
  logic core_start_o, core_short_o, busy_o;
  logic [11:0] data_o, data_oe_o;

  int n_chk = 0, n_bad = 0, n_start = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  adc_host_if dut (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (core_start_o) n_start <= n_start + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // full conversion with protocol checks; leaves rd_nconv_i high
  task automatic convert(input logic short_cyc, input logic [11:0] val);
    int s0;
    byte_addr_i = short_cyc;
    step(2);
    s0 = n_start;
    rd_nconv_i = 1'b0;
    step(2);
    check("R1 busy before latency", {11'b0, busy_o}, 12'h000);
    step(1);
    check("R1 busy rise", {11'b0, busy_o}, 12'h001);
    check("R2 start pulse", {11'b0, core_start_o}, 12'h001);
    check("R3 short flag", {11'b0, core_short_o}, {11'b0, short_cyc});
    rd_nconv_i = 1'b1;
    step(1);
    check("R2 start width", {11'b0, core_start_o}, 12'h000);
    step(3);
    check("R5 oe while busy", data_oe_o, 12'h000);
    check("R5 data while busy", data_o, 12'h000);
    core_done_i = 1'b1;
    core_data_i = val;
    step(1);
    core_done_i = 1'b0;
    core_data_i = 12'h000;
    check("R4 busy fall", {11'b0, busy_o}, 12'h000);
    check("R2 single start", 12'(n_start - s0), 12'h001);
  endtask

  // {short, word_sel, addr, core data, exp data, exp oe}
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 12'hA5C, 12'hA5C, 12'hFFF},
    {1'b0, 1'b0, 1'b0, 12'hA5C, 12'h0A5, 12'h0FF},
    {1'b0, 1'b0, 1'b1, 12'hA5C, 12'h0C0, 12'h0FF},
    {1'b1, 1'b1, 1'b0, 12'h3B7, 12'h3B0, 12'hFFF},
    {1'b1, 1'b0, 1'b1, 12'h3B7, 12'h000, 12'h0FF},
    {1'b0, 1'b1, 1'b0, 12'h000, 12'h000, 12'hFFF},
    {1'b0, 1'b1, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF},
    {1'b0, 1'b0, 1'b0, 12'hFFF, 12'h0FF, 12'h0FF}
  };

  initial begin
    int s0;
    string tag;
    step(2);
    check("R7 reset busy", {11'b0, busy_o}, 12'h000);
    check("R7 reset oe", data_oe_o, 12'h000);
    rst_ni = 1'b1;
    step(3);
    check("R7 deselected oe", data_oe_o, 12'h000);
    check("R1 no start idle", {11'b0, busy_o}, 12'h000);

    // R12: two-edge latency on the read path
    sel_ni = 1'b0;
    step(1);
    check("R12 one edge", data_oe_o, 12'h000);
    step(1);
    check("R12 two edges", data_oe_o, 12'hFFF);

    for (int i = 0; i < 8; i++) begin
      convert(VEC[i][38], VEC[i][35:24]);
      word_sel_i  = VEC[i][37];
      byte_addr_i = VEC[i][36];
      step(2);
      tag = VEC[i][37] ? "R8 word" : (VEC[i][36] ? "R10 low nibble" : "R9 high byte");
      if (VEC[i][38]) tag = {tag, " after R3 short"};
      check(tag, data_o, VEC[i][23:12]);
      check(tag, data_oe_o, VEC[i][11:0]);
    end

    // R6: edges and control changes during busy are ignored
    word_sel_i = 1'b1; byte_addr_i = 1'b0;
    step(2);
    s0 = n_start;
    rd_nconv_i = 1'b0;
    step(3);
    rd_nconv_i = 1'b1;
    step(3);
    rd_nconv_i = 1'b0;
    en_i = 1'b0; sel_ni = 1'b1;
    step(4);
    en_i = 1'b1; sel_ni = 1'b0;
    step(2);
    check("R6 still busy", {11'b0, busy_o}, 12'h001);
    core_done_i = 1'b1; core_data_i = 12'h123;
    step(1);
    core_done_i = 1'b0;
    step(6);
    check("R6 no late restart", {11'b0, busy_o}, 12'h000);
    check("R6 start count", 12'(n_start - s0), 12'h001);
    rd_nconv_i = 1'b1;
    step(2);
    check("R4 latched result", data_o, 12'h123);

    // R1: start blocked when deselected or disabled
    s0 = n_start;
    sel_ni = 1'b1;
    step(2);
    rd_nconv_i = 1'b0;
    step(4);
    check("R1 select blocks", {11'b0, busy_o}, 12'h000);
    rd_nconv_i = 1'b1; sel_ni = 1'b0; en_i = 1'b0;
    step(2);
    check("R7 disabled oe", data_oe_o, 12'h000);
    rd_nconv_i = 1'b0;
    step(4);
    check("R1 enable blocks", {11'b0, busy_o}, 12'h000);
    check("R1 no start pulses", 12'(n_start - s0), 12'h000);
    rd_nconv_i = 1'b1; en_i = 1'b1;
    step(2);

    // R7: read/convert low disables the bus before busy rises
    rd_nconv_i = 1'b0;
    step(2);
    check("R7 convert level oe", data_oe_o, 12'h000);
    step(1);
    check("R1 start from read state", {11'b0, busy_o}, 12'h001);
    rd_nconv_i = 1'b1;
    core_done_i = 1'b1; core_data_i = 12'h456;
    step(1);
    core_done_i = 1'b0;
    step(2);

    // R11: stand-alone wiring
    sel_ni = 1'b0; byte_addr_i = 1'b0; en_i = 1'b1; word_sel_i = 1'b1;
    convert(1'b0, 12'h5A6);
    check("R11 stand-alone data", data_o, 12'h5A6);
    check("R11 stand-alone oe", data_oe_o, 12'hFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule